// File: doc/BRIEF.md
# Single-Port Multicycle RISC Datapath

This block is a deliberately lean 16-bit processor datapath. All architectural state lives in one 16-entry register file that has a single port, so only one register can be read or written in any cycle. Every register read drives one shared internal bus. The adder/nand unit takes one operand from that bus and the other from a temporary register. The program counter is not a separate register: it is register 1. The constant used to advance it sits in register 2. Register 0 always reads as zero.

A small sequencer steps through a three-cycle fetch and a three-cycle execute phase, so each instruction takes six cycles. Instruction memory is external and synchronous: the block drives an address and receives the word one cycle later. After a halt instruction the block stops. A debug selector then reads any register out through the same single port.

Top module: `risc_mc_core`

## Requirements
- R1: The register file is accessed through one port. It is written only in the second fetch step (the PC update) and in the third execute step (the result write).
- R2: Register 0 reads as zero. Writes that target register 0 leave it reading zero.
- R3: After reset, register 1 (PC) is 0, register 2 is 2, and every other register is 0. `halted` is low and the sequencer is in its first fetch step.
- R4: The second fetch step writes PC+2 (using the value in register 2 loaded into the temp register) back to register 1 and presents it on `mem_addr` in that same cycle. The first address after reset is therefore 2. The instruction register captures `mem_rdata` one cycle later.
- R5: Instruction layout: opcode in bits [15:12], destination rd in [11:8], source ra in [7:4], source rb in [3:0]. `mem_addr` is a byte address, and word n of memory sits at address 2n.
- R6: Opcode 0 (add) writes r[ra] + r[rb], modulo 2^16, to r[rd].
- R7: Opcode 1 (nand) writes ~(r[ra] & r[rb]) to r[rd].
- R8: Opcodes 2 to 14 execute as add.
- R9: Opcode 15 (halt) raises `halted` at the end of the first execute step. `halted` then stays high, and no register changes after that.
- R10: Every non-halt instruction takes exactly 6 cycles. A program of N such instructions followed by a halt asserts `halted` 6N+4 clock edges after reset is released.
- R11: While `halted` is high, `dbg_data` shows r[`dbg_sel`] combinationally. While `halted` is low, `dbg_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Instruction memory byte address |
| mem_rdata | input | 16 | Instruction word, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_sel | input | 4 | Register selected for the debug view |
| dbg_data | output | 16 | Selected register while halted, otherwise 0 |

## Verification
Timing follows a fixed schedule. The PC update appears on `mem_addr` one edge after reset is released. The k-th instruction word is captured at edge 6k-3. Its result is written at edge 6k. A halt raises `halted` at edge 6N+4.

The bench samples on the falling edge, so it reads each value after the rising edge that produces it. It counts rising edges from reset release until `halted` rises and compares that count with 6N+4.

Register contents are read through the debug port only after the halt, and they are compared with a reference interpreter in the bench. After the halt, the bench lets ten more edges pass and confirms that `halted` and the PC have not changed.

// File: rtl/risc_pkg.sv
// Package: shared sequencer state type and instruction constants.
// Assumes a 4-bit opcode field; field positions are fixed by the encoding.
package risc_pkg;
    typedef enum logic [2:0] {
        ST_FETCH0 = 3'd0,
        ST_FETCH1 = 3'd1,
        ST_FETCH2 = 3'd2,
        ST_EXEC0  = 3'd3,
        ST_EXEC1  = 3'd4,
        ST_EXEC2  = 3'd5,
        ST_HALT   = 3'd6
    } seq_state_t;

    localparam logic [3:0] OPC_ADD  = 4'd0;
    localparam logic [3:0] OPC_NAND = 4'd1;
    localparam logic [3:0] OPC_HALT = 4'd15;

    localparam int REG_ZERO = 0;
    localparam int REG_PC   = 1;
    localparam int REG_STEP = 2;
endpackage

// File: rtl/risc_regfile.sv
// Single-ported register file: one asynchronous read and one synchronous
// write share a single address. Entry 0 is hardwired to zero, and writes
// to it are dropped. Reset loads STEP_VAL into the step entry and clears
// all other entries.
module risc_regfile #(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 16,
    parameter int STEP_IDX = 2,
    parameter int STEP_VAL = 2,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Storage update: reset values, otherwise one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= (i == STEP_IDX) ? DATA_W'(STEP_VAL) : '0;
            end
        end else if (we && addr != '0) begin
            cells[addr] <= wdata;
        end
    end

    // Read path: entry 0 always returns zero.
    always_comb begin
        rdata = (addr == '0) ? '0 : cells[addr];
    end
endmodule

// File: rtl/risc_alu.sv
// Two-function ALU: add or nand. Assumes both operands have the same width
// and that the add wraps modulo 2^DATA_W.
module risc_alu #(
    parameter int DATA_W = 16
) (
    input  logic              do_nand,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    // Function select.
    always_comb begin
        res = do_nand ? ~(opa & opb) : (opa + opb);
    end
endmodule

// File: rtl/risc_seq.sv
// Control sequencer: runs three fetch steps and then three execute steps.
// The halt opcode is decoded in the first execute step, and the halt state
// is terminal until reset.
module risc_seq
    import risc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] opcode,
    output seq_state_t state
);
    seq_state_t state_nx;

    // Next-state selection.
    always_comb begin
        unique case (state)
            ST_FETCH0: state_nx = ST_FETCH1;
            ST_FETCH1: state_nx = ST_FETCH2;
            ST_FETCH2: state_nx = ST_EXEC0;
            ST_EXEC0:  state_nx = (opcode == OPC_HALT) ? ST_HALT : ST_EXEC1;
            ST_EXEC1:  state_nx = ST_EXEC2;
            ST_EXEC2:  state_nx = ST_FETCH0;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_FETCH0;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH0;
        else        state <= state_nx;
    end
endmodule

// File: rtl/risc_mc_core.sv
// Multicycle datapath top. All register traffic goes over one bus fed by
// the single register-file port. The ALU combines that bus with the temp
// register. Assumes instruction memory returns data one cycle after the
// address is presented.
module risc_mc_core
    import risc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREGS  = 16,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    input  logic [AW-1:0]     dbg_sel,
    output logic [DATA_W-1:0] dbg_data
);
    seq_state_t        state;
    logic [DATA_W-1:0] t_q, mar_q, ir_q;
    logic [DATA_W-1:0] bus, alu_y, port_wdata;
    logic [AW-1:0]     port_addr;
    logic              port_we, use_nand;
    logic [3:0]        opcode;
    logic [AW-1:0]     fld_rd, fld_ra, fld_rb;

    assign opcode = ir_q[15:12];
    assign fld_rd = ir_q[8 +: AW];
    assign fld_ra = ir_q[4 +: AW];
    assign fld_rb = ir_q[0 +: AW];

    risc_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .state  (state)
    );

    // Port steering: choose which register drives the bus this cycle.
    always_comb begin
        port_addr = '0;
        port_we   = 1'b0;
        unique case (state)
            ST_FETCH0: port_addr = AW'(REG_STEP);
            ST_FETCH1: begin port_addr = AW'(REG_PC); port_we = 1'b1; end
            ST_EXEC0:  port_addr = fld_ra;
            ST_EXEC1:  port_addr = fld_rb;
            ST_EXEC2:  begin port_addr = fld_rd; port_we = 1'b1; end
            ST_HALT:   port_addr = dbg_sel;
            default:   port_addr = '0;
        endcase
    end

    assign port_wdata = (state == ST_EXEC2) ? t_q : alu_y;
    assign use_nand   = (state == ST_EXEC1) && (opcode == OPC_NAND);

    risc_regfile #(
        .DATA_W   (DATA_W),
        .DEPTH    (NREGS),
        .STEP_IDX (REG_STEP),
        .STEP_VAL (2)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (port_addr),
        .we    (port_we),
        .wdata (port_wdata),
        .rdata (bus)
    );

    risc_alu #(.DATA_W(DATA_W)) u_alu (
        .do_nand (use_nand),
        .opa     (bus),
        .opb     (t_q),
        .res     (alu_y)
    );

    // Datapath registers: temp, memory address and instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q   <= '0;
            mar_q <= '0;
            ir_q  <= '0;
        end else begin
            unique case (state)
                ST_FETCH0: t_q   <= bus;
                ST_FETCH1: mar_q <= alu_y;
                ST_FETCH2: ir_q  <= mem_rdata;
                ST_EXEC0:  t_q   <= bus;
                ST_EXEC1:  t_q   <= alu_y;
                default:   ;
            endcase
        end
    end

    // Address output: the new PC goes out in the same cycle it is formed.
    assign mem_addr = (state == ST_FETCH1) ? alu_y : mar_q;

    assign halted   = (state == ST_HALT);
    assign dbg_data = halted ? bus : '0;
endmodule

// File: rtl/risc_mc_core_chk.sv
// Checker for risc_mc_core: protocol properties of the sequencer and of
// the single register port. Attached to the top by the bind below.
module risc_mc_core_chk
    import risc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input seq_state_t  state,
    input logic [3:0]  port_addr,
    input logic        port_we,
    input logic [15:0] bus,
    input logic [15:0] t_q,
    input logic        halted
);
    AST_WRITE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |-> (state == ST_FETCH1 || state == ST_EXEC2)); // R1
    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr == 4'd0) |-> (bus == 16'd0)); // R2
    AST_STEP_IN_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH1) |-> (t_q == 16'd2)); // R4
    AST_FETCH_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH0) |=> (state == ST_FETCH1)); // R10
    AST_EXEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC2) |=> (state == ST_FETCH0)); // R10
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !port_we)); // R9
endmodule

bind risc_mc_core risc_mc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .port_addr (port_addr),
    .port_we   (port_we),
    .bus       (bus),
    .t_q       (t_q),
    .halted    (halted)
);

// File: tb/risc_mc_core_tb_top.sv
// Directed bench: a memory model, a reference interpreter, and one task
// per scenario.
module risc_mc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_rdata, dbg_data;
    logic        halted;
    logic [3:0]  dbg_sel = '0;

    logic [15:0] mem [256];
    logic [15:0] ref_r [16];
    int          n_checks = 0;
    int          n_fail = 0;
    int          total_cyc = 0;

    always #5 clk = ~clk;

    risc_mc_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .dbg_sel   (dbg_sel),
        .dbg_data  (dbg_data)
    );

    // Synchronous memory model: one-cycle read latency, word at addr/2.
    always @(posedge clk) mem_rdata <= mem[mem_addr[8:1]];

    // Watchdog.
    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", total_cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int rd, input int ra, input int rb);
        return {op[3:0], rd[3:0], ra[3:0], rb[3:0]};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = enc(15, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reference interpreter: returns the number of non-halt instructions.
    function automatic int ref_run();
        logic [15:0] pc = 16'd0;
        logic [15:0] w, a, b, y;
        int n = 0;
        for (int i = 0; i < 16; i++) ref_r[i] = (i == 2) ? 16'd2 : 16'd0;
        for (int k = 0; k < 200; k++) begin
            pc = pc + 16'd2;
            ref_r[1] = pc;
            w = mem[pc[8:1]];
            if (w[15:12] == 4'd15) return n;
            a = ref_r[w[7:4]];
            b = ref_r[w[3:0]];
            y = (w[15:12] == 4'd1) ? ~(a & b) : a + b;
            if (w[11:8] != 4'd0) ref_r[w[11:8]] = y;
            n++;
        end
        return n;
    endfunction

    // Runs the loaded program from reset; checks cycle count and registers.
    task automatic run_and_compare(input string tag);
        int exp_n;
        int cyc = 0;
        exp_n = ref_run();
        do_reset();
        while (!halted && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (!halted) check({tag, " R11 dbg idle"}, dbg_data, 16'd0);
        end
        check({tag, " R10 cycles to halt"}, 16'(cyc), 16'(6 * exp_n + 4));
        for (int i = 0; i < 16; i++) begin
            dbg_sel = 4'(i);
            #1;
            check({tag, " R6 R7 R8 R11 reg"}, dbg_data, ref_r[i]);
        end
        dbg_sel = 4'd0;
        #1;
        check({tag, " R2 r0 zero"}, dbg_data, 16'd0);
    endtask

    task automatic t_reset();
        clear_mem();
        do_reset();
        #1;
        check("R3 halted low", {15'd0, halted}, 16'd0);
        check("R3 R11 dbg idle", dbg_data, 16'd0);
        @(posedge clk);
        @(negedge clk);
        check("R4 first pc on mem_addr", mem_addr, 16'd2);
        // Halt-only program exposes the reset values of r2 and others.
        mem[1] = enc(15, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R9 halt after first exec step", {15'd0, halted}, 16'd1);
        dbg_sel = 4'd2;
        #1;
        check("R3 r2 reset value", dbg_data, 16'd2);
        dbg_sel = 4'd7;
        #1;
        check("R3 r7 reset value", dbg_data, 16'd0);
        dbg_sel = 4'd1;
        #1;
        check("R4 pc after halt fetch", dbg_data, 16'd2);
    endtask

    task automatic t_arith();
        clear_mem();
        mem[1] = enc(0, 3, 2, 2);     // r3 = 4
        mem[2] = enc(0, 4, 3, 2);     // r4 = 6
        mem[3] = enc(0, 5, 4, 1);     // r5 = 6 + pc
        mem[4] = enc(1, 6, 5, 3);     // nand
        mem[5] = enc(0, 0, 3, 3);     // write to r0 dropped
        mem[6] = enc(7, 7, 3, 4);     // R8 opcode 7 as add
        mem[7] = enc(14, 8, 6, 5);    // R8 opcode 14 as add
        mem[8] = enc(1, 9, 0, 0);     // nand of zeros: ffff
        mem[9] = enc(0, 10, 9, 9);    // wrap: fffe
        run_and_compare("arith");
    endtask

    task automatic t_chain();
        clear_mem();
        for (int i = 1; i <= 12; i++) mem[i] = enc(i % 2, 3 + (i % 5), 3 + ((i + 2) % 5), 1 + (i % 3));
        run_and_compare("chain");
    endtask

    task automatic t_halt_sticky();
        logic [15:0] pc_seen;
        dbg_sel = 4'd1;
        #1;
        pc_seen = dbg_data;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R9 halted stays", {15'd0, halted}, 16'd1);
        check("R9 pc frozen", dbg_data, pc_seen);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_halt_sticky();
        t_chain();
        t_halt_sticky();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule